// File: doc/BRIEF.md
# BCD Calendar Days-in-Month Decoder

This unit supports the date display of a watch controller. Each cycle it samples a binary month number and a calendar year given as four BCD digits, and one clock later it presents three registered results: a four-wire one-hot code telling whether the month is 28, 29, 30 or 31 days long, a leap-year flag, and a flag marking an illegal input.

The leap decision is made on the decimal digits themselves. No binary conversion takes place. Divisibility by 4 comes from the parity of a tens digit and the low bits of the ones digit. Divisibility by 100 means the two low digits are zero. Divisibility by 400 applies the same pair test to the upper two digits. The unit keeps no date, does not count time and does not drive a display.

Top module: `cal_days_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: Outputs are registered. A change on the inputs reaches the outputs at the first rising clock edge after it, and not before.
- R3: For months 1 to 12 (binary), months 4, 6, 9 and 11 raise `days_oh[2]` (30 days). Months 1, 3, 5, 7, 8, 10 and 12 raise `days_oh[3]` (31 days).
- R4: Month 2 raises `days_oh[1]` (29 days) when the leap flag is high, and `days_oh[0]` (28 days) when it is low.
- R5: With all digits valid, a year whose two low digits are not both zero is a leap year exactly when that two-digit value is divisible by 4.
- R6: With all digits valid, a year whose two low digits are both zero is a leap year exactly when the two high digits, read as one number, are divisible by 4.
- R7: Month values 0 and 13 to 15 drive all four day wires low and raise `bad_input`. The leap flag still follows the year.
- R8: If any year digit exceeds 9, `bad_input` is high and `leap` is low. The day wires are then decoded from the month as for a common year.
- R9: At most one day wire is ever high. With a valid month, exactly one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| month | input | 4 | Month number in binary, 1 = first month |
| year_bcd | input | 16 | Year as BCD: [15:12] thousands, [11:8] hundreds, [7:4] tens, [3:0] ones |
| days_oh | output | 4 | One-hot month length: bit 0 = 28, bit 1 = 29, bit 2 = 30, bit 3 = 31 |
| leap | output | 1 | Year is a leap year |
| bad_input | output | 1 | Month outside 1..12 or any year digit above 9 |

## Verification
Two things can act in the same cycle: the February length choice and the rejection of a malformed year. The bench drives month 2 together with a year that has a digit above 9. It expects `bad_input` high, `leap` low and the 28-day wire high, so the forced-low leap flag must be the one that feeds the month decode. It also drives an illegal month together with an illegal digit and expects every day wire low. Outside these cases, every year from 0000 to 9999 is compared against an integer remainder rule, and every month value is checked against a case-based length table.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned DIGIT_W     = 4;
  localparam int unsigned YEAR_DIGITS = 4;
  localparam int unsigned MONTH_W     = 4;
  localparam int unsigned LEN_W       = 4;
  localparam int unsigned LAST_MONTH  = 12;
  localparam int unsigned MAX_DIGIT   = 9;

  typedef enum logic [1:0] {
    LEN_28 = 2'd0,
    LEN_29 = 2'd1,
    LEN_30 = 2'd2,
    LEN_31 = 2'd3
  } len_idx_e;

  typedef struct packed {
    logic [LEN_W-1:0] days;
    logic             leap;
    logic             bad;
  } cal_result_t;
endpackage

// File: rtl/bcd_pair_div4.sv
module bcd_pair_div4 #(
  parameter int unsigned DW = cal_pkg::DIGIT_W
) (
  input  logic [DW-1:0] hi_digit,
  input  logic [DW-1:0] lo_digit,
  output logic          div4
);
  // Ten is 2 mod 4, so the pair is divisible by 4 when
  // (2*parity(hi) + lo[1:0]) mod 4 == 0. The valid digits 8 and 9 add 0 and 1.
  always_comb begin
    if (hi_digit[0])
      div4 = lo_digit[1] & ~lo_digit[0];
    else
      div4 = ~lo_digit[1] & ~lo_digit[0];
  end
endmodule

// File: rtl/bcd_leap_eval.sv
module bcd_leap_eval #(
  parameter int unsigned DW = cal_pkg::DIGIT_W,
  parameter int unsigned ND = cal_pkg::YEAR_DIGITS,
  localparam int unsigned YW = DW * ND
) (
  input  logic [YW-1:0] year_bcd,
  output logic          is_leap,
  output logic          digits_ok
);
  logic [ND-1:0] dig_ok;
  logic          low_div4;
  logic          high_div4;
  logic          low_zero;

  for (genvar g = 0; g < ND; g++) begin : g_digit_chk
    assign dig_ok[g] = (year_bcd[g*DW +: DW] <= DW'(cal_pkg::MAX_DIGIT));
  end

  bcd_pair_div4 #(.DW(DW)) u_low_pair (
    .hi_digit (year_bcd[2*DW-1:DW]),
    .lo_digit (year_bcd[DW-1:0]),
    .div4     (low_div4)
  );

  bcd_pair_div4 #(.DW(DW)) u_high_pair (
    .hi_digit (year_bcd[4*DW-1:3*DW]),
    .lo_digit (year_bcd[3*DW-1:2*DW]),
    .div4     (high_div4)
  );

  assign low_zero  = (year_bcd[2*DW-1:0] == '0);
  assign digits_ok = &dig_ok;

  // leap = div4 and not century, or div400
  always_comb begin
    is_leap = 1'b0;
    if (digits_ok) begin
      if (low_zero) is_leap = high_div4;
      else          is_leap = low_div4;
    end
  end
endmodule

// File: rtl/month_len_decode.sv
module month_len_decode #(
  parameter int unsigned MW = cal_pkg::MONTH_W,
  parameter int unsigned LW = cal_pkg::LEN_W
) (
  input  logic [MW-1:0] month,
  input  logic          leap,
  output logic [LW-1:0] days_oh,
  output logic          month_ok
);
  import cal_pkg::*;

  always_comb begin
    month_ok = (month != '0) && (month <= MW'(LAST_MONTH));
    days_oh  = '0;
    if (month_ok) begin
      case (month)
        MW'(2):                   days_oh[leap ? LEN_29 : LEN_28] = 1'b1;
        MW'(4), MW'(6), MW'(9),
        MW'(11):                  days_oh[LEN_30] = 1'b1;
        default:                  days_oh[LEN_31] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cal_days_decoder.sv
module cal_days_decoder #(
  parameter int unsigned MONTH_W = cal_pkg::MONTH_W,
  parameter int unsigned DIGIT_W = cal_pkg::DIGIT_W,
  parameter int unsigned NDIG    = cal_pkg::YEAR_DIGITS,
  localparam int unsigned YEAR_W = DIGIT_W * NDIG,
  localparam int unsigned LEN_W  = cal_pkg::LEN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MONTH_W-1:0] month,
  input  logic [YEAR_W-1:0]  year_bcd,
  output logic [LEN_W-1:0]   days_oh,
  output logic               leap,
  output logic               bad_input
);
  import cal_pkg::*;

  logic             leap_c;
  logic             digits_ok_c;
  logic             month_ok_c;
  logic [LEN_W-1:0] days_c;
  cal_result_t      res_q;

  bcd_leap_eval #(.DW(DIGIT_W), .ND(NDIG)) u_leap (
    .year_bcd  (year_bcd),
    .is_leap   (leap_c),
    .digits_ok (digits_ok_c)
  );

  month_len_decode #(.MW(MONTH_W), .LW(LEN_W)) u_len (
    .month    (month),
    .leap     (leap_c),
    .days_oh  (days_c),
    .month_ok (month_ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q.days <= days_c;
      res_q.leap <= leap_c;
      res_q.bad  <= ~(month_ok_c & digits_ok_c);
    end
  end

  assign days_oh   = res_q.days;
  assign leap      = res_q.leap;
  assign bad_input = res_q.bad;

  // Checks against the port-level contract
  function automatic logic year_has_bad_digit(input logic [YEAR_W-1:0] y);
    logic b;
    b = 1'b0;
    for (int i = 0; i < NDIG; i++)
      if (y[i*DIGIT_W +: DIGIT_W] > DIGIT_W'(MAX_DIGIT)) b = 1'b1;
    return b;
  endfunction

  assert_len_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    (month >= MONTH_W'(1) && month <= MONTH_W'(LAST_MONTH)) |=> ($countones(days_oh) == 1));

  assert_len_atmost_one_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(days_oh));

  assert_bad_month_R7: assert property (@(posedge clk) disable iff (rst)
    (month == '0 || month > MONTH_W'(LAST_MONTH)) |=> (days_oh == '0 && bad_input));

  assert_bad_digit_R8: assert property (@(posedge clk) disable iff (rst)
    year_has_bad_digit(year_bcd) |=> (bad_input && !leap));

  assert_feb_follows_leap_R4: assert property (@(posedge clk) disable iff (rst)
    (month == MONTH_W'(2)) |=> (days_oh[LEN_29] == leap && days_oh[LEN_28] == !leap));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (days_oh == '0 && !leap && !bad_input));
endmodule

// File: tb/test_cal_days_decoder.sv
module test_cal_days_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  month = '0;
  logic [15:0] year_bcd = '0;
  logic [3:0]  days_oh;
  logic        leap;
  logic        bad_input;

  int n_tests = 0;
  int n_fail  = 0;

  cal_days_decoder i_cal_days_decoder (
    .clk       (clk),
    .rst       (rst),
    .month     (month),
    .year_bcd  (year_bcd),
    .days_oh   (days_oh),
    .leap      (leap),
    .bad_input (bad_input)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] to_bcd(input int y);
    return {4'(y/1000), 4'((y/100)%10), 4'((y/10)%10), 4'(y%10)};
  endfunction

  function automatic logic ref_leap(input int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic logic [3:0] ref_days(input int m, input logic lp);
    case (m)
      1, 3, 5, 7, 8, 10, 12: return 4'b1000;
      4, 6, 9, 11:           return 4'b0100;
      2:                     return lp ? 4'b0010 : 4'b0001;
      default:               return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s month=%0d year=%h act days/leap/bad=%b exp=%b",
               req, month, year_bcd, act, exp);
    end
  endtask

  // Drive one vector at a falling edge, sample one cycle later at the next falling edge.
  task automatic apply(input int m, input logic [15:0] ybcd);
    @(negedge clk);
    month    = 4'(m);
    year_bcd = ybcd;
    @(negedge clk);
  endtask

  task automatic run_valid(input string req, input int m, input int y);
    logic lp;
    logic mbad;
    apply(m, to_bcd(y));
    lp   = ref_leap(y);
    mbad = (m < 1 || m > 12);
    check(req, {days_oh, leap, bad_input}, {ref_days(m, lp), lp, mbad});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    month = 4'd2; year_bcd = 16'h2000;
    repeat (3) @(negedge clk);
    check("R1", {days_oh, leap, bad_input}, 6'b0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    apply(1, to_bcd(2023));
    check("R2", {days_oh, leap, bad_input}, 6'b1000_0_0);
    month = 4'd2; year_bcd = 16'h2024;
    #1;
    check("R2", {days_oh, leap, bad_input}, 6'b1000_0_0);
    @(posedge clk); #1;
    check("R2", {days_oh, leap, bad_input}, 6'b0010_1_0);
  endtask

  task automatic t_year_sweep;
    for (int y = 0; y < 10000; y++)
      run_valid(((y % 100) == 0) ? "R6" : "R5", 2, y);
  endtask

  task automatic t_feb_corners;
    run_valid("R4", 2, 2024);
    run_valid("R4", 2, 2023);
    run_valid("R6", 2, 1900);
    run_valid("R6", 2, 2000);
    run_valid("R6", 2, 0);
  endtask

  task automatic t_month_sweep;
    int yrs[4] = '{2023, 2024, 1900, 2000};
    foreach (yrs[k])
      for (int m = 0; m < 16; m++)
        run_valid((m < 1 || m > 12) ? "R7" : ((m == 2) ? "R4" : "R3"), m, yrs[k]);
  endtask

  task automatic t_bad_digits;
    logic [15:0] bad_years[6] = '{16'h2A24, 16'hF000, 16'h200C, 16'h19B6, 16'h2E00, 16'hAAAA};
    foreach (bad_years[k]) begin
      for (int m = 0; m < 16; m++) begin
        apply(m, bad_years[k]);
        check("R8", {days_oh, leap, bad_input}, {ref_days(m, 1'b0), 1'b0, 1'b1});
        check("R9", {3'b0, ($countones(days_oh) <= 1), 2'b0}, {3'b0, 1'b1, 2'b0});
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_feb_corners();
    t_month_sweep();
    t_bad_digits();
    t_year_sweep();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {days_oh, leap, bad_input}, 6'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule